// File: doc/BRIEF.md
# Barrel Shifter with Carry

A 32-bit combinational shifter that turns a data word, an operation code and a shift length into a shifted word and a carry-out. It supports five operations: arithmetic right shift, logical right shift, logical left shift, rotate right, and a one-bit rotate right that shifts the incoming carry into the top bit. The shift length is eight bits wide, so requests of 32 or more are legal. Their results and carry-outs follow fixed saturation and wrap rules.

The block sits in an execution datapath where it produces the second operand or a shift result. A flag-update enable decides whether the carry computed by the shifter reaches the carry output. When the enable is low, the incoming carry passes through. The parameter `REG_OUT` selects an optional register stage on both outputs. That stage has an asynchronous active-low reset.

Top module: `barrel_shift_carry`

## Requirements
- R1: With a shift length of 0, operations ASR (op 0), LSR (op 1), LSL (op 2) and ROR (op 3) return the data word unchanged, and the carry-out equals the carry-in.
- R2: ASR (op 0) with length n in 1..31 fills the top n bits with data bit 31, and the carry is data bit n-1.
- R3: ASR with a length of 32 or more gives every result bit and the carry equal to data bit 31.
- R4: LSR (op 1) with n in 1..31 fills the top n bits with zero, and the carry is bit n-1. For n of 32 or more the result is 0. The carry is bit 31 at n = 32 and 0 for n of 33 or more.
- R5: LSL (op 2) with n in 1..31 fills the low n bits with zero, and the carry is bit 32-n. For n of 32 or more the result is 0. The carry is bit 0 at n = 32 and 0 for n of 33 or more.
- R6: ROR (op 3) moves the low bits into the top bits and gives a carry of bit n-1. A nonzero length that is a multiple of 32 returns the data unchanged with a carry of bit 31. Any other length above 32 acts as the length modulo 32.
- R7: RRX (op 4) shifts right by one, places the carry-in in bit 31 and gives a carry of data bit 0, whatever the shift length.
- R8: When the flag-update enable is 0, carry_o equals carry_i for every operation.
- R9: Op codes 5, 6 and 7 return the data word unchanged, and the carry-out equals the carry-in.
- R10: With REG_OUT = 1, both outputs appear one clock after their inputs, and reset drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 32 | Word to shift |
| op_i | input | 3 | Operation code: 0 ASR, 1 LSR, 2 LSL, 3 ROR, 4 RRX |
| amt_i | input | 8 | Shift length, 0..255 |
| carry_i | input | 1 | Incoming carry flag |
| flag_en_i | input | 1 | 1 lets the shifter carry reach carry_o |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
The bench builds the block at its default 32-bit width with an 8-bit length and REG_OUT = 1. This exercises the register stage and its reset value along with the shifting logic. Because the length field is only 8 bits, the bench can sweep every length from 0 to 255 for all eight op codes. It does so for four data words, both carry-in values and both enable values. The sweep therefore reaches every boundary: 0, 31, 32, 33, every multiple of 32 under rotate, and 255. Each result is compared against a model that applies single-bit steps n times.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    OP_ASR = 3'd0,
    OP_LSR = 3'd1,
    OP_LSL = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shift_op_e;
endpackage

// File: rtl/bsc_len_decode.sv
module bsc_len_decode #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic             zero_o,
  output logic             full_o,
  output logic             over_o,
  output logic [SH_W-1:0]  rot_o,
  output logic             rot_full_o
);
  localparam logic [AMT_W-1:0] WIDTH_LEN = AMT_W'(DATA_W);

  always_comb begin
    zero_o     = (amt_i == '0);
    full_o     = (amt_i == WIDTH_LEN);
    over_o     = (amt_i > WIDTH_LEN);
    // DATA_W is a power of two, so the low bits give the length modulo DATA_W
    rot_o      = amt_i[SH_W-1:0];
    rot_full_o = !zero_o && (rot_o == '0);
  end
endmodule

// File: rtl/bsc_shift_core.sv
module bsc_shift_core #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              fill_i,
  input  logic              rot_i,
  input  logic              rev_i,
  output logic [DATA_W-1:0] data_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] stage [SH_W+1];

  // left shift is done as right shift on the bit-reversed word
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      src[i] = rev_i ? data_i[DATA_W-1-i] : data_i[i];
  end

  assign stage[0] = src;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [STEP-1:0] wrap;
    assign wrap         = rot_i ? stage[s][STEP-1:0] : {STEP{fill_i}};
    assign stage[s+1]   = amt_i[s] ? {wrap, stage[s][DATA_W-1:STEP]} : stage[s];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      data_o[i] = rev_i ? stage[SH_W][DATA_W-1-i] : stage[SH_W][i];
  end

  // last bit shifted out; meaningless for amt_i == 0, the caller ignores it
  assign carry_o = src[amt_i - 1'b1];
endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
  import bsc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b0,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic            len_zero, len_full, len_over, rot_full;
  logic [SH_W-1:0] rot_amt;
  logic [DATA_W-1:0] core_res;
  logic            core_c;
  logic            msb;
  logic            core_fill, core_rot, core_rev;
  logic [DATA_W-1:0] res_d;
  logic            sh_c, carry_d;

  assign msb = data_i[DATA_W-1];

  bsc_len_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_len (
    .amt_i      (amt_i),
    .zero_o     (len_zero),
    .full_o     (len_full),
    .over_o     (len_over),
    .rot_o      (rot_amt),
    .rot_full_o (rot_full)
  );

  assign core_fill = (op_i == OP_ASR) ? msb : 1'b0;
  assign core_rot  = (op_i == OP_ROR);
  assign core_rev  = (op_i == OP_LSL);

  bsc_shift_core #(.DATA_W(DATA_W)) i_core (
    .data_i  (data_i),
    .amt_i   (rot_amt),
    .fill_i  (core_fill),
    .rot_i   (core_rot),
    .rev_i   (core_rev),
    .data_o  (core_res),
    .carry_o (core_c)
  );

  always_comb begin
    res_d = data_i;
    sh_c  = carry_i;
    unique case (op_i)
      OP_ASR: begin
        if (len_full || len_over) begin
          res_d = {DATA_W{msb}};
          sh_c  = msb;
        end else if (!len_zero) begin
          res_d = core_res;
          sh_c  = core_c;
        end
      end
      OP_LSR: begin
        if (len_full || len_over) begin
          res_d = '0;
          sh_c  = len_full ? msb : 1'b0;
        end else if (!len_zero) begin
          res_d = core_res;
          sh_c  = core_c;
        end
      end
      OP_LSL: begin
        if (len_full || len_over) begin
          res_d = '0;
          sh_c  = len_full ? data_i[0] : 1'b0;
        end else if (!len_zero) begin
          res_d = core_res;
          sh_c  = core_c;
        end
      end
      OP_ROR: begin
        if (rot_full) begin
          sh_c = msb;
        end else if (!len_zero) begin
          res_d = core_res;
          sh_c  = core_c;
        end
      end
      OP_RRX: begin
        res_d = {carry_i, data_i[DATA_W-1:1]};
        sh_c  = data_i[0];
      end
      default: ;
    endcase
  end

  assign carry_d = flag_en_i ? sh_c : carry_i;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o <= '0;
        carry_o  <= 1'b0;
      end else begin
        result_o <= res_d;
        carry_o  <= carry_d;
      end
    end
  end else begin : g_comb
    assign result_o = res_d;
    assign carry_o  = carry_d;
  end

  a_r1_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amt_i == '0 && op_i < 3'd4) |-> (res_d == data_i && sh_c == carry_i));

  a_r3_asr_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ASR && amt_i >= AMT_W'(DATA_W)) |-> (res_d == {DATA_W{msb}} && sh_c == msb));

  a_r4_lsr_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LSR && amt_i > AMT_W'(DATA_W)) |-> (res_d == '0 && !sh_c));

  a_r5_lsl_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LSL && amt_i != '0) |-> !res_d[0]);

  a_r6_ror_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ROR) |-> ($countones(res_d) == $countones(data_i)));

  a_r7_rrx_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RRX) |-> (res_d[DATA_W-1] == carry_i && sh_c == data_i[0]));
endmodule

// File: tb/test_barrel_shift_carry.sv
module test_barrel_shift_carry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data;
  logic [2:0]  op;
  logic [7:0]  amt;
  logic        cin, fen;
  logic [31:0] res;
  logic        cout;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  barrel_shift_carry #(.DATA_W(32), .AMT_W(8), .REG_OUT(1'b1)) i_barrel_shift_carry (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .op_i(op), .amt_i(amt),
    .carry_i(cin), .flag_en_i(fen), .result_o(res), .carry_o(cout)
  );

  // single-bit steps repeated n times; the carry is the last bit out
  function automatic logic [32:0] model(logic [31:0] d, logic [2:0] o, logic [7:0] n,
                                        logic ci, logic fe);
    logic [31:0] x = d;
    logic c = ci;
    case (o)
      3'd0: for (int i = 0; i < int'(n); i++) begin c = x[0];  x = {x[31], x[31:1]}; end
      3'd1: for (int i = 0; i < int'(n); i++) begin c = x[0];  x = {1'b0, x[31:1]}; end
      3'd2: for (int i = 0; i < int'(n); i++) begin c = x[31]; x = {x[30:0], 1'b0}; end
      3'd3: for (int i = 0; i < int'(n); i++) begin c = x[0];  x = {x[0], x[31:1]}; end
      3'd4: begin c = x[0]; x = {ci, x[31:1]}; end
      default: ;
    endcase
    return {fe ? c : ci, x};
  endfunction

  function automatic string tag(logic [2:0] o, logic [7:0] n);
    if (o > 3'd4) return "R9";
    if (o == 3'd4) return "R7";
    if (n == 8'd0) return "R1";
    case (o)
      3'd0:    return (n < 8'd32) ? "R2" : "R3";
      3'd1:    return "R4";
      3'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d amt=%0d data=%h: actual %h expected %h",
               req, op, amt, data, act, exp);
    end
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'hA5C3_0F96;
    pats[2] = 32'h7FFF_FFFE;
    pats[3] = 32'h1234_5678;
    data = 32'hFFFF_FFFF; op = 3'd0; amt = 8'd5; cin = 1'b1; fen = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", res, 32'h0);
    check("R10", {31'h0, cout}, 32'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 8; o++)
        for (int a = 0; a < 256; a++)
          for (int k = 0; k < 4; k++) begin
            logic [32:0] exp;
            @(negedge clk);
            data = pats[p]; op = 3'(o); amt = 8'(a); cin = k[0]; fen = k[1];
            exp = model(data, op, amt, cin, fen);
            @(negedge clk);  // one register stage: R10 latency
            check(tag(op, amt), res, exp[31:0]);
            check(fen ? tag(op, amt) : "R8", {31'h0, cout}, {31'h0, exp[32]});
          end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule